// File: doc/BRIEF.md
# Frame Table Store and Sequencer

This block keeps the sensor clocking program: eight tables of sixteen 34-bit rows. Each row carries a dwell count, a follow-on table number, a two-bit action code and a 25-bit pattern word for the waveform stage downstream. Software loads the tables through a write strobe. A write flagged as an address sets the write pointer once. Each row write after that stores one row and steps the pointer. The pointer carries from the last row of one table into the first row of the next.

When the write path is closed, a sequencer walks the tables. It holds each row for a number of line periods set by the row's count field, then applies the row's action. The action can step to the next row, loop back to the top of the table, jump to another table, or park until the vertical-drive input rises. A vertical-drive rising edge also restarts the walk from the first row of table 0. The memory has a single port, so while the write path is open the sequencer is parked and its outputs read as zero.

Top module: `ftab_seq_top`

## Requirements
- R1: While rst_ni is low, row_o, table_o and row_idx_o are zero and the write pointer is cleared to table 0, row 0.
- R2: Address writes and row writes take effect only when prog_mode_i or low_power_i is high. In any other cycle a strobe changes neither the memory nor the write pointer.
- R3: A write with wr_is_addr_i high loads the write pointer from wr_data_i[6:0], with the table number in bits [6:4] and the row number in bits [3:0].
- R4: A write with wr_is_addr_i low stores wr_data_i at the write pointer and then adds one to the pointer. Row 15 of table n is followed by row 0 of table (n+1) mod 8.
- R5: While the write path is open, the sequencer position is reset to table 0, row 0. From the next clock edge the outputs read zero. After the path closes, the walk starts at table 0, row 0.
- R6: Row layout: bits [33:30] hold the count, [29:27] the next table, [26:25] the action code and [24:0] the pattern. When the sequencer runs, row_o presents the full stored row at table_o/row_idx_o.
- R7: A row is held for count+1 line_tick_i pulses. Its action is applied on the clock edge that samples the last of those pulses.
- R8: Action 00 steps to the next row. From row 15 it steps to row 0 of table (table+1) mod 8.
- R9: Action 01 returns to row 0 of the same table.
- R10: Action 10 moves to row 0 of the table named in the next-table field.
- R11: Action 11 parks on the row and ignores line ticks until a vertical-drive rising edge. That edge moves the walk to row 0 of the row's next-table.
- R12: A vertical-drive rising edge is vd_i high after a cycle with vd_i low. When the sequencer is not parked, this edge sends it to table 0, row 0 with the count cleared, and it takes precedence over a line tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_mode_i | input | 1 | Programming mode select, opens the write path |
| low_power_i | input | 1 | Low-power state, also opens the write path |
| wr_valid_i | input | 1 | Write strobe, one cycle per write |
| wr_is_addr_i | input | 1 | Marks the strobe as an address load |
| wr_data_i | input | 34 | Row data, or pointer in bits [6:0] |
| vd_i | input | 1 | Vertical-drive level |
| line_tick_i | input | 1 | One-cycle pulse per line period |
| row_o | output | 34 | Row at the current sequencer position, zero when parked |
| table_o | output | 3 | Current table index |
| row_idx_o | output | 4 | Current row index |

## Verification
A wrong write pointer stays hidden while programming continues. It shows up on the first cycle after the write path closes, or later when the walk reaches the misplaced row: row_o then carries the wrong pattern, or table_o/row_idx_o take a wrong branch. A dwell counter that is off by one moves a transition by exactly one line tick, so the index outputs disagree with the reference in the cycle after that tick. Every output is compared against a behavioural model on every clock. A broken vertical-drive edge detector or a broken parking state therefore shows up on the clock edge that follows the vd_i rise.

// File: rtl/ftab_pkg.sv
package ftab_pkg;
  parameter int unsigned TBL_N = 8;
  parameter int unsigned ROW_N = 16;
  localparam int unsigned TBL_W  = $clog2(TBL_N);
  localparam int unsigned RIDX_W = $clog2(ROW_N);
  localparam int unsigned ADDR_W = TBL_W + RIDX_W;
  localparam int unsigned DEPTH  = TBL_N * ROW_N;
  localparam int unsigned CNT_W  = 4;
  localparam int unsigned FLG_W  = 2;
  localparam int unsigned PAY_W  = 25;
  localparam int unsigned FLG_LO = PAY_W;
  localparam int unsigned NXT_LO = FLG_LO + FLG_W;
  localparam int unsigned CNT_LO = NXT_LO + TBL_W;
  localparam int unsigned ROW_W  = CNT_LO + CNT_W;
  localparam int unsigned CTL_W  = ROW_W - PAY_W;

  typedef enum logic [FLG_W-1:0] {
    ACT_STEP = 2'b00,
    ACT_LOOP = 2'b01,
    ACT_JUMP = 2'b10,
    ACT_PARK = 2'b11
  } act_e;
endpackage

// File: rtl/ftab_wr_ctrl.sv
module ftab_wr_ctrl
  import ftab_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_en_i,
  input  logic              wr_valid_i,
  input  logic              wr_is_addr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o
);
  logic [ADDR_W-1:0] wptr_q;
  logic              take;

  assign take    = acc_en_i & wr_valid_i;
  assign we_o    = take & ~wr_is_addr_i;
  assign waddr_o = wptr_q;

  // flat pointer: row carry rolls into the table field
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           wptr_q <= '0;
    else if (take) begin
      if (wr_is_addr_i)    wptr_q <= wr_addr_i;
      else                 wptr_q <= wptr_q + 1'b1;
    end
  end

  // R2
  wptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_en_i |=> $stable(wptr_q));
  // R4
  wptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && wr_valid_i && !wr_is_addr_i) |=> wptr_q == $past(wptr_q) + 1'b1);
  // R3
  wptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && wr_valid_i && wr_is_addr_i) |=> wptr_q == $past(wr_addr_i));
endmodule

// File: rtl/ftab_mem.sv
module ftab_mem
  import ftab_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [ROW_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [ROW_W-1:0]  rdata_o
);
  logic [ROW_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  // R4
  row_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/ftab_seq.sv
module ftab_seq
  import ftab_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_en_i,
  input  logic              vd_i,
  input  logic              line_tick_i,
  input  logic [CTL_W-1:0]  ctl_i,
  output logic [TBL_W-1:0]  tbl_o,
  output logic [RIDX_W-1:0] ridx_o,
  output logic              run_o
);
  logic [TBL_W-1:0]  tbl_q;
  logic [RIDX_W-1:0] ridx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              park_q, run_q, vd_q;

  logic              vd_rise, dwell_done, last_row;
  logic [CNT_W-1:0]  cnt_f;
  logic [TBL_W-1:0]  nxt_f;
  act_e              act_f;

  assign cnt_f      = ctl_i[CTL_W-1 -: CNT_W];
  assign nxt_f      = ctl_i[FLG_W +: TBL_W];
  assign act_f      = act_e'(ctl_i[FLG_W-1:0]);
  assign vd_rise    = vd_i & ~vd_q;
  assign dwell_done = (cnt_q == cnt_f);
  assign last_row   = (ridx_q == RIDX_W'(ROW_N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vd_q <= 1'b0;
    else         vd_q <= vd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= '0; ridx_q <= '0; cnt_q <= '0; park_q <= 1'b0; run_q <= 1'b0;
    end else if (acc_en_i) begin
      tbl_q <= '0; ridx_q <= '0; cnt_q <= '0; park_q <= 1'b0; run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (vd_rise) begin
        cnt_q  <= '0;
        ridx_q <= '0;
        park_q <= 1'b0;
        tbl_q  <= park_q ? nxt_f : '0;
      end else if (line_tick_i && !park_q) begin
        if (!dwell_done) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          unique case (act_f)
            ACT_STEP: begin
              ridx_q <= last_row ? '0 : ridx_q + 1'b1;
              if (last_row) tbl_q <= tbl_q + 1'b1;
            end
            ACT_LOOP: ridx_q <= '0;
            ACT_JUMP: begin
              tbl_q  <= nxt_f;
              ridx_q <= '0;
            end
            ACT_PARK: park_q <= 1'b1;
          endcase
        end
      end
    end
  end

  assign tbl_o  = tbl_q;
  assign ridx_o = ridx_q;
  assign run_o  = run_q;

  // R12
  vd_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_en_i && vd_rise && !park_q) |=> (tbl_q == '0 && ridx_q == '0 && cnt_q == '0));
  // R11
  park_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_en_i && park_q && !vd_rise) |=> ($stable(tbl_q) && $stable(ridx_q) && park_q));
  // R7
  dwell_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q <= cnt_f);
  // R9
  loop_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_en_i && !vd_rise && line_tick_i && !park_q && dwell_done && act_f == ACT_LOOP)
      |=> (ridx_q == '0 && $stable(tbl_q)));
endmodule

// File: rtl/ftab_seq_top.sv
module ftab_seq_top
  import ftab_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_mode_i,
  input  logic              low_power_i,
  input  logic              wr_valid_i,
  input  logic              wr_is_addr_i,
  input  logic [ROW_W-1:0]  wr_data_i,
  input  logic              vd_i,
  input  logic              line_tick_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [TBL_W-1:0]  table_o,
  output logic [RIDX_W-1:0] row_idx_o
);
  logic              acc_en, we, run;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [ROW_W-1:0]  rdata;
  logic [TBL_W-1:0]  tbl;
  logic [RIDX_W-1:0] ridx;

  assign acc_en = prog_mode_i | low_power_i;
  assign raddr  = {tbl, ridx};

  ftab_wr_ctrl u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_en_i     (acc_en),
    .wr_valid_i   (wr_valid_i),
    .wr_is_addr_i (wr_is_addr_i),
    .wr_addr_i    (wr_data_i[ADDR_W-1:0]),
    .we_o         (we),
    .waddr_o      (waddr)
  );

  ftab_mem u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wr_data_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  ftab_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_en_i    (acc_en),
    .vd_i        (vd_i),
    .line_tick_i (line_tick_i),
    .ctl_i       (rdata[ROW_W-1:PAY_W]),
    .tbl_o       (tbl),
    .ridx_o      (ridx),
    .run_o       (run)
  );

  assign row_o     = run ? rdata : '0;
  assign table_o   = tbl;
  assign row_idx_o = ridx;

  // R5
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en |=> (row_o == '0 && table_o == '0 && row_idx_o == '0));
endmodule

// File: tb/ftab_seq_top_tb_top.sv
module ftab_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_mode = 1'b1, low_power = 1'b0;
  logic        wr_valid = 1'b0, wr_is_addr = 1'b0;
  logic [33:0] wr_data = '0;
  logic        vd = 1'b0, tick = 1'b0;
  logic [33:0] row_o;
  logic [2:0]  table_o;
  logic [3:0]  row_idx_o;

  always #10 clk = ~clk;

  ftab_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .prog_mode_i(prog_mode), .low_power_i(low_power),
    .wr_valid_i(wr_valid), .wr_is_addr_i(wr_is_addr), .wr_data_i(wr_data),
    .vd_i(vd), .line_tick_i(tick),
    .row_o(row_o), .table_o(table_o), .row_idx_o(row_idx_o)
  );

  int    n_vec = 0, n_bad = 0, cyc = 0;
  string phase = "R1";

  // behavioural reference
  logic [33:0] mem_m [128];
  int m_wp, m_tbl, m_row, m_cnt;
  bit m_park, m_run, m_vdq;

  function automatic logic [33:0] mk(int c, int nxt, int act, int pay);
    return {c[3:0], nxt[2:0], act[1:0], pay[24:0]};
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_wp = 0; m_tbl = 0; m_row = 0; m_cnt = 0; m_park = 0; m_run = 0; m_vdq = 0;
    end else begin
      logic [33:0] cur;
      bit acc, rise;
      acc  = prog_mode || low_power;
      cur  = mem_m[m_tbl*16 + m_row];
      rise = vd && !m_vdq;
      m_vdq = vd;
      if (acc && wr_valid) begin
        if (wr_is_addr) m_wp = int'(wr_data[6:0]);
        else begin mem_m[m_wp] = wr_data; m_wp = (m_wp + 1) % 128; end
      end
      if (acc) begin
        m_run = 0; m_tbl = 0; m_row = 0; m_cnt = 0; m_park = 0;
      end else begin
        m_run = 1;
        if (rise) begin
          m_tbl = m_park ? int'(cur[29:27]) : 0;
          m_row = 0; m_cnt = 0; m_park = 0;
        end else if (tick && !m_park) begin
          if (m_cnt != int'(cur[33:30])) m_cnt++;
          else begin
            m_cnt = 0;
            case (cur[26:25])
              2'b00: begin
                if (m_row == 15) begin m_row = 0; m_tbl = (m_tbl + 1) % 8; end
                else m_row++;
              end
              2'b01: m_row = 0;
              2'b10: begin m_tbl = int'(cur[29:27]); m_row = 0; end
              default: m_park = 1;
            endcase
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [33:0] e_row;
    e_row = m_run ? mem_m[m_tbl*16 + m_row] : 34'h0;
    n_vec++;
    if (row_o !== e_row || table_o !== 3'(m_tbl) || row_idx_o !== 4'(m_row)) begin
      n_bad++;
      $display("FAIL %s: row=%h tbl=%0d idx=%0d expected row=%h tbl=%0d idx=%0d",
               phase, row_o, table_o, row_idx_o, e_row, m_tbl, m_row);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected < 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic wr_addr(int a);
    @(negedge clk); wr_valid = 1; wr_is_addr = 1; wr_data = 34'(a);
    @(negedge clk); wr_valid = 0; wr_is_addr = 0; wr_data = '0;
  endtask

  task automatic wr_row(logic [33:0] d);
    @(negedge clk); wr_valid = 1; wr_is_addr = 0; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic lines(int n);
    repeat (n) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic vd_pulse();
    @(negedge clk); vd = 1;
    repeat (2) @(negedge clk);
    vd = 0;
    @(negedge clk);
  endtask

  initial begin
    phase = "R1";
    repeat (4) @(negedge clk);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    phase = "R4";
    wr_addr(0);
    for (int i = 0; i < 128; i++) wr_row(mk(0, 0, 0, 25'h100 + i));
    phase = "R3";
    wr_addr(18);
    wr_row(mk(2, 0, 1, 25'h0_9999));        // table 1 row 2 loops
    phase = "R4";
    wr_addr(127);
    wr_row(mk(0, 0, 0, 25'h155));
    wr_row(mk(1, 0, 0, 25'hABC));           // wraps to table 0 row 0
    repeat (2) @(negedge clk);

    phase = "R5";
    prog_mode = 0;
    repeat (3) @(negedge clk);
    phase = "R6";
    @(negedge clk);
    phase = "R7";
    lines(3);
    phase = "R8";
    lines(16);
    phase = "R9";
    lines(10);
    phase = "R12";
    vd_pulse();
    lines(1);
    @(negedge clk); vd = 1; tick = 1;       // vd beats a tick
    @(negedge clk); vd = 0; tick = 0;
    repeat (2) @(negedge clk);

    phase = "R2";
    wr_addr(7'h50);
    wr_row(34'h3_FFFF_FFFF);
    repeat (3) @(negedge clk);
    low_power = 1;
    wr_row(mk(0, 5, 2, 25'h777));           // lands at pointer 1
    phase = "R3";
    wr_addr(7'h50);
    wr_row(mk(0, 3, 3, 25'h5));
    wr_addr(7'h30);
    wr_row(mk(0, 0, 1, 25'h33));
    low_power = 0;
    repeat (2) @(negedge clk);

    phase = "R10";
    lines(3);
    phase = "R11";
    lines(5);
    vd_pulse();
    lines(3);
    phase = "R12";
    vd_pulse();
    lines(4);

    phase = "R5";
    prog_mode = 1;
    repeat (3) @(negedge clk);
    prog_mode = 0;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule